// File: doc/BRIEF.md
# Small-Page NAND Command Sequencer

This block issues a single command to a small-page NAND device that has 512-byte pages. The requester supplies a command code, an optional column and an optional page address on a valid/ready handshake. The sequencer holds chip enable for the whole operation. It writes the command byte with the command latch line high, then emits the address bytes with the address latch line high, then waits for the condition that completes that command. When the condition is met it pulses `done_o` for one cycle and returns to idle.

For a program-data-entry command, the sequencer first writes a pointer command that selects the page region the column falls in. It then sends the column relative to that region. Reads wait on a synchronised ready/busy pin, or wait a fixed time when the pin is absent. A device reset completes once the device's status byte reports ready. The requester does not touch the bus strobes. Every byte cycle uses a setup, strobe-low and hold time, each given as a number of clock cycles.

Top module: `nand_cmd_seq`

## Requirements
- R1: When the command is 0x80 (serial data input), a pointer byte goes out before it. The pointer is 0x50 when the column is 512 or more, 0x01 when the column is from 256 to 511, and 0x00 when the column is below 256 or no column is given.
- R2: The column byte on the bus is the column minus 512 after pointer 0x50, minus 256 after pointer 0x01, and unchanged otherwise.
- R3: Every command byte is written with `nand_cle_o` high and `nand_ale_o` low. Every address byte is written with `nand_ale_o` high and `nand_cle_o` low. The two lines are never high together.
- R4: When neither column nor page is present, no address byte is written and `nand_ale_o` stays low for the whole operation.
- R5: Address bytes go out in this order: the column (if present), page[7:0], page[15:8], then {4'h0, page[19:16]}. The fourth page byte is sent only when bit 26 or bit 27 of `DEV_BYTES` is set.
- R6: Commands 0x10, 0x60, 0xD0, 0x70 and 0x80 complete right after their last byte, with no wait.
- R7: Command 0xFF is followed by status command 0x70. Status reads with `nand_re_no` low then repeat until a read byte has bit 6 set. Other bits have no effect.
- R8: Any other command waits after its last byte. With `HAS_RB`=1, `done_o` comes three cycles after `nand_rb_i` returns high: two synchroniser flops plus one state register. With `HAS_RB`=0, it waits `CLK_MHZ*20` cycles.
- R9: Each byte cycle drives the data for `HOLD_CYC` cycles, then holds the write strobe low for `LOW_CYC` cycles, then holds the data for `HOLD_CYC` cycles. Data is stable when the strobe rises.
- R10: Out of reset, `req_ready_o`=1, `done_o`=0, `nand_ce_no`=1, `nand_we_no`=1, `nand_re_no`=1, and both latch lines are low. During an operation `req_ready_o` is 0 and `nand_ce_no` is 0. `done_o` is a one-cycle pulse, after which the block is ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Idle, request accepted |
| req_cmd_i | input | 8 | Command code |
| req_col_vld_i | input | 1 | Column present |
| req_col_i | input | 10 | Column (0..527) |
| req_page_vld_i | input | 1 | Page address present |
| req_page_i | input | 20 | Page address |
| done_o | output | 1 | One-cycle completion pulse |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe_o | output | 1 | Data bus drive enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb_i | input | 1 | Ready (1) / busy (0) |

## Verification
The bench builds two instances. The first has a 64 MiB device size, a ready/busy pin, a 3-cycle strobe and a 2-cycle hold. It covers the fourth address byte, pointer selection, column rebasing, reset polling and the three-cycle latency after busy releases. The second has a 16 MiB size, no ready/busy pin and `CLK_MHZ`=10, giving a 200-cycle fixed wait. It covers the three-byte page address and the timed read completion within a short run.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam logic [7:0] CMD_READ0   = 8'h00;
  localparam logic [7:0] CMD_READ1   = 8'h01;
  localparam logic [7:0] CMD_READOOB = 8'h50;
  localparam logic [7:0] CMD_SEQIN   = 8'h80;
  localparam logic [7:0] CMD_PROG    = 8'h10;
  localparam logic [7:0] CMD_ERASE1  = 8'h60;
  localparam logic [7:0] CMD_ERASE2  = 8'hD0;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_RESET   = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PTR, ST_CMD, ST_ADDR, ST_POLL_CMD, ST_POLL_RD,
    ST_GUARD, ST_WAIT_RB, ST_WAIT_FIX, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD} strobe_ph_e;

  function automatic logic no_wait_cmd(input logic [7:0] c);
    return (c == CMD_PROG) || (c == CMD_ERASE1) || (c == CMD_ERASE2) ||
           (c == CMD_STATUS) || (c == CMD_SEQIN);
  endfunction
endpackage

// File: rtl/nand_ptr_sel.sv
module nand_ptr_sel import nand_seq_pkg::*; #(
  parameter int PAGE_BYTES = 512,
  parameter int COL_W      = 10
) (
  input  logic             col_vld_i,
  input  logic [COL_W-1:0] col_i,
  output logic [7:0]       ptr_cmd_o,
  output logic [7:0]       col_o
);
  localparam int HALF = PAGE_BYTES / 2;
  localparam logic [COL_W-1:0] PAGE_C = COL_W'(PAGE_BYTES);
  localparam logic [COL_W-1:0] HALF_C = COL_W'(HALF);

  logic [COL_W-1:0] rebased;

  always_comb begin
    ptr_cmd_o = CMD_READ0;
    rebased   = col_i;
    if (col_vld_i) begin
      if (col_i >= PAGE_C) begin
        ptr_cmd_o = CMD_READOOB;
        rebased   = col_i - PAGE_C;
      end else if (col_i >= HALF_C) begin
        ptr_cmd_o = CMD_READ1;
        rebased   = col_i - HALF_C;
      end
    end
    col_o = rebased[7:0];
  end
endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rb_i,
  output logic rb_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], rb_i};
  end

  assign rb_o = sync_q[STAGES-1];
endmodule

// File: rtl/nand_strobe.sv
module nand_strobe import nand_seq_pkg::*; #(
  parameter int HOLD_CYC = 2,
  parameter int LOW_CYC  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] dq_i,
  output logic [7:0] dq_o,
  output logic       dq_oe_o,
  output logic       we_no,
  output logic       re_no,
  output logic [7:0] rdata_o,
  output logic       done_o
);
  localparam int MAXC = (HOLD_CYC > LOW_CYC) ? HOLD_CYC : LOW_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] LOW_LD  = CW'(LOW_CYC - 1);

  strobe_ph_e ph_q;
  logic [CW-1:0] cnt_q;
  logic          rd_q;
  logic [7:0]    data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      data_q  <= '0;
      rdata_o <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (go_i) begin
          ph_q   <= PH_SETUP;
          cnt_q  <= HOLD_LD;
          rd_q   <= rd_i;
          data_q <= wdata_i;
        end
        PH_SETUP: if (cnt_q == '0) begin
          ph_q  <= PH_LOW;
          cnt_q <= LOW_LD;
        end else cnt_q <= cnt_q - 1'b1;
        PH_LOW: if (cnt_q == '0) begin
          ph_q  <= PH_HOLD;
          cnt_q <= HOLD_LD;
          if (rd_q) rdata_o <= dq_i;
        end else cnt_q <= cnt_q - 1'b1;
        default: if (cnt_q == '0) ph_q <= PH_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign done_o  = (ph_q == PH_HOLD) && (cnt_q == '0);
  assign we_no   = !((ph_q == PH_LOW) && !rd_q);
  assign re_no   = !((ph_q == PH_LOW) && rd_q);
  assign dq_oe_o = (ph_q != PH_IDLE) && !rd_q;
  assign dq_o    = data_q;

  // strobe-low length measured independently of the phase counter
  logic [7:0] low_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_len_q <= '0;
    else if (!we_no) low_len_q <= low_len_q + 1'b1;
    else             low_len_q <= '0;
  end

  a_r9_we_low_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> (low_len_q == 8'(LOW_CYC)));
  a_r9_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> $stable(dq_o));
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq import nand_seq_pkg::*; #(
  parameter logic [31:0] DEV_BYTES  = 32'h0400_0000,
  parameter int          PAGE_BYTES = 512,
  parameter int          COL_W      = 10,
  parameter int          PAGE_W     = 20,
  parameter bit          HAS_RB     = 1'b1,
  parameter int          CLK_MHZ    = 100,
  parameter int          WAIT_US    = 20,
  parameter int          TWB_CYC    = 4,
  parameter int          HOLD_CYC   = 2,
  parameter int          LOW_CYC    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [7:0]        req_cmd_i,
  input  logic              req_col_vld_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_page_vld_i,
  input  logic [PAGE_W-1:0] req_page_i,
  output logic              done_o,
  output logic              nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [7:0]        nand_dq_i,
  input  logic              nand_rb_i
);
  localparam bit FOUR_ADDR = DEV_BYTES[26] | DEV_BYTES[27];
  localparam int FIX_CYC   = CLK_MHZ * WAIT_US;
  localparam int WMAX      = (FIX_CYC > TWB_CYC) ? FIX_CYC : TWB_CYC;
  localparam int WCW       = $clog2(WMAX + 1);
  localparam logic [WCW-1:0] FIX_LD = WCW'(FIX_CYC - 1);
  localparam logic [WCW-1:0] TWB_LD = WCW'(TWB_CYC - 1);
  localparam logic [2:0] PAGE_BYTES_N = FOUR_ADDR ? 3'd3 : 3'd2;

  seq_state_e    state_q, post_st;
  logic [7:0]    cmd_q, ptr_q, col_q;
  logic          has_col_q, has_page_q, poll_ok_q;
  logic [PAGE_W-1:0] page_q;
  logic [2:0]    aidx_q, naddr_q, abyte_sel;
  logic [WCW-1:0] wcnt_q;
  logic [7:0]    ptr_d, col_d, addr_byte, wdata;
  logic          stb_go, stb_rd, stb_done, rb_s;
  logic [7:0]    stb_rdata;
  logic          is_rd_cmd;

  nand_ptr_sel #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) u_ptr (
    .col_vld_i(req_col_vld_i), .col_i(req_col_i),
    .ptr_cmd_o(ptr_d), .col_o(col_d)
  );

  nand_rb_sync #(.STAGES(2)) u_rb (
    .clk_i(clk_i), .rst_ni(rst_ni), .rb_i(nand_rb_i), .rb_o(rb_s)
  );

  nand_strobe #(.HOLD_CYC(HOLD_CYC), .LOW_CYC(LOW_CYC)) u_stb (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(stb_go), .rd_i(stb_rd),
    .wdata_i(wdata), .dq_i(nand_dq_i), .dq_o(nand_dq_o),
    .dq_oe_o(nand_dq_oe_o), .we_no(nand_we_no), .re_no(nand_re_no),
    .rdata_o(stb_rdata), .done_o(stb_done)
  );

  assign is_rd_cmd = !no_wait_cmd(cmd_q) && (cmd_q != CMD_RESET);

  always_comb begin
    if (no_wait_cmd(cmd_q))     post_st = ST_DONE;
    else if (cmd_q == CMD_RESET) post_st = ST_POLL_CMD;
    else if (HAS_RB)            post_st = ST_GUARD;
    else                        post_st = ST_WAIT_FIX;
  end

  // address byte index skips the column slot when no column was given
  assign abyte_sel = has_col_q ? aidx_q : aidx_q + 3'd1;

  always_comb begin
    case (abyte_sel)
      3'd0:    addr_byte = col_q;
      3'd1:    addr_byte = page_q[7:0];
      3'd2:    addr_byte = page_q[15:8];
      default: addr_byte = {4'h0, page_q[19:16]};
    endcase
  end

  always_comb begin
    case (state_q)
      ST_PTR:      wdata = ptr_q;
      ST_CMD:      wdata = cmd_q;
      ST_ADDR:     wdata = addr_byte;
      ST_POLL_CMD: wdata = CMD_STATUS;
      default:     wdata = 8'h00;
    endcase
  end

  assign stb_go = (state_q == ST_PTR) || (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                  (state_q == ST_POLL_CMD) || (state_q == ST_POLL_RD);
  assign stb_rd = (state_q == ST_POLL_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cmd_q      <= '0;
      ptr_q      <= '0;
      col_q      <= '0;
      has_col_q  <= 1'b0;
      has_page_q <= 1'b0;
      page_q     <= '0;
      aidx_q     <= '0;
      naddr_q    <= '0;
      wcnt_q     <= '0;
      poll_ok_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          cmd_q      <= req_cmd_i;
          ptr_q      <= ptr_d;
          col_q      <= (req_cmd_i == CMD_SEQIN) ? col_d : req_col_i[7:0];
          has_col_q  <= req_col_vld_i;
          has_page_q <= req_page_vld_i;
          page_q     <= req_page_i;
          naddr_q    <= (req_col_vld_i ? 3'd1 : 3'd0) +
                        (req_page_vld_i ? PAGE_BYTES_N : 3'd0);
          aidx_q     <= '0;
          poll_ok_q  <= 1'b0;
          state_q    <= (req_cmd_i == CMD_SEQIN) ? ST_PTR : ST_CMD;
        end
        ST_PTR: if (stb_done) state_q <= ST_CMD;
        ST_CMD, ST_ADDR: if (stb_done) begin
          if ((state_q == ST_CMD && naddr_q != 3'd0) ||
              (state_q == ST_ADDR && aidx_q != naddr_q - 3'd1)) begin
            if (state_q == ST_ADDR) aidx_q <= aidx_q + 3'd1;
            state_q <= ST_ADDR;
          end else begin
            state_q <= post_st;
            wcnt_q  <= HAS_RB ? TWB_LD : FIX_LD;
          end
        end
        ST_POLL_CMD: if (stb_done) state_q <= ST_POLL_RD;
        ST_POLL_RD: if (stb_done && stb_rdata[6]) begin
          poll_ok_q <= 1'b1;
          state_q   <= ST_DONE;
        end
        ST_GUARD: if (wcnt_q == '0) state_q <= ST_WAIT_RB;
                  else wcnt_q <= wcnt_q - 1'b1;
        ST_WAIT_RB: if (rb_s) state_q <= ST_DONE;
        ST_WAIT_FIX: if (wcnt_q == '0) state_q <= ST_DONE;
                     else wcnt_q <= wcnt_q - 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign nand_ce_no  = (state_q == ST_IDLE);
  assign nand_cle_o  = (state_q == ST_PTR) || (state_q == ST_CMD) || (state_q == ST_POLL_CMD);
  assign nand_ale_o  = (state_q == ST_ADDR);

  a_r3_cle_ale_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));
  a_r3_we_with_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_no |-> (nand_cle_o || nand_ale_o));
  a_r4_ale_needs_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_ale_o |-> (has_col_q || has_page_q));
  a_r7_reset_polled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cmd_q == CMD_RESET) |-> poll_ok_q);
  a_r8_rb_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_rd_cmd && HAS_RB) |-> $past(rb_s));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_ce_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> !nand_ce_no);
endmodule

// File: tb/tb_nand_cmd_seq.sv
module tb_nand_cmd_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       val_a = 0, val_b = 0;
  logic [7:0] cmd = 0;
  logic       cv = 0, pv = 0;
  logic [9:0] col = 0;
  logic [19:0] page = 0;
  logic [7:0] dq_in;
  logic       rb_a = 1;
  logic       sel = 0;
  int         rd_n = 0;

  logic rdy_a, done_a, ce_a, cle_a, ale_a, we_a, re_a, oe_a;
  logic rdy_b, done_b, ce_b, cle_b, ale_b, we_b, re_b, oe_b;
  logic [7:0] dq_a, dq_b;

  nand_cmd_seq #(.DEV_BYTES(32'h0400_0000), .HAS_RB(1'b1), .HOLD_CYC(2), .LOW_CYC(3)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(val_a), .req_ready_o(rdy_a),
    .req_cmd_i(cmd), .req_col_vld_i(cv), .req_col_i(col), .req_page_vld_i(pv),
    .req_page_i(page), .done_o(done_a), .nand_ce_no(ce_a), .nand_cle_o(cle_a),
    .nand_ale_o(ale_a), .nand_we_no(we_a), .nand_re_no(re_a), .nand_dq_o(dq_a),
    .nand_dq_oe_o(oe_a), .nand_dq_i(dq_in), .nand_rb_i(rb_a));

  nand_cmd_seq #(.DEV_BYTES(32'h0100_0000), .HAS_RB(1'b0), .CLK_MHZ(10),
                 .HOLD_CYC(1), .LOW_CYC(2)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(val_b), .req_ready_o(rdy_b),
    .req_cmd_i(cmd), .req_col_vld_i(cv), .req_col_i(col), .req_page_vld_i(pv),
    .req_page_i(page), .done_o(done_b), .nand_ce_no(ce_b), .nand_cle_o(cle_b),
    .nand_ale_o(ale_b), .nand_we_no(we_b), .nand_re_no(re_b), .nand_dq_o(dq_b),
    .nand_dq_oe_o(oe_b), .nand_dq_i(dq_in), .nand_rb_i(1'b1));

  wire       m_we   = sel ? we_b : we_a;
  wire       m_re   = sel ? re_b : re_a;
  wire       m_cle  = sel ? cle_b : cle_a;
  wire       m_ale  = sel ? ale_b : ale_a;
  wire [7:0] m_dq   = sel ? dq_b : dq_a;
  wire       m_done = sel ? done_b : done_a;
  wire       m_rdy  = sel ? rdy_b : rdy_a;

  // status byte model: bit 6 clear (other bits set) for two reads, then ready
  assign dq_in = (rd_n >= 2) ? 8'h40 : 8'hBF;

  int checks = 0, fails = 0;
  logic [7:0] cap_b [16];
  logic       cap_c [16];
  logic       cap_a [16];
  int   cap_n = 0;
  int   ale_seen = 0;
  time  t_wfall = 0, t_wrise = 0, t_done = 0, t_rel = 0;
  int   we_width = 0;

  logic [7:0] exp_b [16];
  logic       exp_c [16];
  int   exp_n = 0;

  always @(negedge m_we) t_wfall = $time;
  always @(posedge m_we) begin
    if (cap_n < 16) begin
      cap_b[cap_n] = m_dq; cap_c[cap_n] = m_cle; cap_a[cap_n] = m_ale;
    end
    cap_n++;
    t_wrise  = $time;
    we_width = int'((t_wrise - t_wfall) / 10);
  end
  always @(posedge m_re) rd_n++;
  always @(posedge clk) if (m_ale) ale_seen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic is_cmd);
    exp_b[exp_n] = b; exp_c[exp_n] = is_cmd; exp_n++;
  endtask

  task automatic cmp_bytes(input string req);
    chk({req, " byte count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n && i < 16; i++) begin
      chk({req, " byte"}, {24'h0, cap_b[i]}, {24'h0, exp_b[i]});
      chk({req, " R3 latch lines"}, {cap_c[i], cap_a[i]}, {exp_c[i], !exp_c[i]});
    end
  endtask

  task automatic run(input logic s, input logic [7:0] c, input logic cvi, input logic [9:0] co,
                     input logic pvi, input logic [19:0] pg);
    int wd;
    @(negedge clk);
    sel = s; cmd = c; cv = cvi; col = co; pv = pvi; page = pg;
    cap_n = 0; exp_n = 0; rd_n = 0; ale_seen = 0;
    if (s) val_b = 1; else val_a = 1;
    @(negedge clk);
    val_a = 0; val_b = 0;
    chk("R10 ready low in operation", m_rdy, 0);
    wd = 0;
    while (!m_done && wd < 5000) begin @(negedge clk); wd++; end
    t_done = $time;
    chk("R10 done reached", m_done, 1);
    @(negedge clk);
    chk("R10 done one cycle", m_done, 0);
    chk("R10 ready after done", m_rdy, 1);
  endtask

  task automatic t_reset_state();
    chk("R10 ready", rdy_a, 1); chk("R10 done", done_a, 0);
    chk("R10 ce", ce_a, 1); chk("R10 we", we_a, 1); chk("R10 re", re_a, 1);
    chk("R10 cle/ale", {cle_a, ale_a}, 0);
  endtask

  task automatic t_seqin_low();
    run(0, 8'h80, 1, 10'h010, 1, 20'h12345);
    push(8'h00, 1); push(8'h80, 1); push(8'h10, 0);
    push(8'h45, 0); push(8'h23, 0); push(8'h01, 0);
    cmp_bytes("R1 R5 R6 seqin low half");
    chk("R9 we low width", we_width, 3);
    chk("R6 no wait", int'((t_done - t_wrise) / 10) <= 4, 1);
  endtask

  task automatic t_seqin_high();
    run(0, 8'h80, 1, 10'd300, 0, 20'h0);
    push(8'h01, 1); push(8'h80, 1); push(8'd44, 0);
    cmp_bytes("R1 R2 seqin second half");
  endtask

  task automatic t_seqin_spare();
    run(0, 8'h80, 1, 10'd515, 0, 20'h0);
    push(8'h50, 1); push(8'h80, 1); push(8'h03, 0);
    cmp_bytes("R1 R2 seqin spare");
  endtask

  task automatic t_erase_page_only();
    run(0, 8'h60, 0, 10'h0, 1, 20'hA5C3E);
    push(8'h60, 1); push(8'h3E, 0); push(8'h5C, 0); push(8'h0A, 0);
    cmp_bytes("R5 R6 erase page only");
  endtask

  task automatic t_status_noaddr();
    run(0, 8'h70, 0, 10'h0, 0, 20'h0);
    push(8'h70, 1);
    cmp_bytes("R4 R6 status");
    chk("R4 ale never high", ale_seen, 0);
  endtask

  task automatic t_reset_poll();
    run(0, 8'hFF, 0, 10'h0, 0, 20'h0);
    push(8'hFF, 1); push(8'h70, 1);
    cmp_bytes("R7 reset");
    chk("R7 status reads until bit6", rd_n, 3);
  endtask

  task automatic t_read_rb();
    fork
      begin
        wait (cap_n == 5);
        #1 rb_a = 0;
        repeat (30) @(negedge clk);
        rb_a = 1; t_rel = $time;
      end
    join_none
    run(0, 8'h00, 1, 10'h005, 1, 20'h00ABC);
    push(8'h00, 1); push(8'h05, 0); push(8'hBC, 0); push(8'h0A, 0); push(8'h00, 0);
    cmp_bytes("R5 read0");
    chk("R8 done three cycles after ready", int'((t_done - t_rel) / 10), 3);
  endtask

  task automatic t_read_fixed();
    int d;
    run(1, 8'h00, 1, 10'h001, 1, 20'h12345);
    push(8'h00, 1); push(8'h01, 0); push(8'h45, 0); push(8'h23, 0);
    cmp_bytes("R5 small device three page bytes");
    chk("R9 we low width b", we_width, 2);
    d = int'((t_done - t_wrise) / 10);
    chk("R8 fixed wait length", (d >= 200) && (d <= 210), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_seqin_low();
    t_seqin_high();
    t_seqin_spare();
    t_erase_page_only();
    t_status_noaddr();
    t_reset_poll();
    t_read_rb();
    t_read_fixed();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule